// File: doc/BRIEF.md
# Held-Key Auto-Repeat Event Generator

This block converts a vector of level-sensitive key inputs into one-cycle event pulses. It samples the keys only on cycles when a poll strobe is high. A key raises an event on the first poll that sees it pressed. If the key is then held, the block stays quiet for a fixed number of polls and afterwards raises an event at a steady interval for as long as the key stays down. Menu and navigation logic use it to get the familiar "press once, then scroll while held" behaviour. The keys are assumed to be debounced already.

Every key has its own signed hold counter. The counter sits at -1 while the key is released and advances by one on each poll that sees the key pressed. When it reaches the end of the repeat interval it folds back to the start of that interval, so a key held for any length of time keeps repeating and the counter never wraps. Events are registered, so an event appears in the cycle after the poll edge that produced it.

Top module: `key_repeat_gen`

## Requirements
- R1: While rst_ni is low, evt_o is all zeros and every hold counter is released (-1). After reset, the first poll that sees a key pressed therefore fires that key.
- R2: On the first poll that sees key k pressed after it was released, evt_o[k] is 1 in the cycle after that poll edge.
- R3: With default parameters, while key k stays held, evt_o[k] stays 0 for the polls numbered 1 to 29 of the hold (poll 0 is the first press).
- R4: A held key fires again on hold poll FIRST_DELAY (30 by default) and then on every REPEAT_EVERY-th poll (6 by default): 36, 42, 48 and so on, for any hold length. The counter stays within -1 to FIRST_DELAY+REPEAT_EVERY-1.
- R5: A poll that sees key k released puts its counter back to -1 and gives evt_o[k]=0. The next poll that sees the key pressed fires it at once.
- R6: On a cycle with poll_i low, the counters hold and in the next cycle evt_o is 0. A press or release that happens only between polls has no effect.
- R7: Keys are independent. One key's press, hold or release does not change another key's events.
- R8: evt_o changes only at clock edges. Before the edge of a firing poll, evt_o is 0. After that edge, evt_o shows that poll's result for exactly one cycle, unless the next cycle is itself a firing poll.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poll_i | input | 1 | Sample strobe; keys are examined only when it is high |
| key_i | input | N_KEYS | Key levels, 1 = pressed |
| evt_o | output | N_KEYS | Registered one-cycle event per key |

## Verification
Two functions can fall on the same poll: the counter fold and the repeat event. On the poll where a held counter wraps from the top of the interval back to FIRST_DELAY, the key must fire exactly as an unbounded counter would. A second coincidence is one key's first press landing on the same poll as another key's repeat. Long holds of up to 200 polls drive many folds, and a second key pressed partway through a hold places a first press next to a repeat. Both are judged against a reference model in the bench. That model keeps an unbounded integer per key and fires when the count is 0, or when it is at least 30 and a multiple of 6, and it is compared with evt_o on every clock.

// File: rtl/key_rpt_pkg.sv
package key_rpt_pkg;
  localparam int unsigned DEF_KEYS  = 7;
  localparam int unsigned DEF_FIRST = 30;
  localparam int unsigned DEF_EVERY = 6;

  // signed counter must span -1 .. first+every-1
  function automatic int unsigned cnt_width(input int unsigned first, input int unsigned every);
    return $clog2(first + every) + 1;
  endfunction
endpackage

// File: rtl/key_hold_cnt.sv
module key_hold_cnt #(
  parameter int unsigned FIRST = 30,
  parameter int unsigned EVERY = 6,
  parameter int unsigned CW    = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 poll_i,
  input  logic                 key_i,
  output logic signed [CW-1:0] cnt_o,
  output logic signed [CW-1:0] cnt_nxt_o
);
  localparam logic signed [CW-1:0] REL_C   = '1;
  localparam logic signed [CW-1:0] TOP_C   = CW'(FIRST + EVERY - 1);
  localparam logic signed [CW-1:0] FIRST_C = CW'(FIRST);
  localparam logic signed [CW-1:0] ONE_C   = CW'(1);

  logic signed [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (poll_i) begin
      if (!key_i)             cnt_d = REL_C;
      else if (cnt_q == TOP_C) cnt_d = FIRST_C;  // fold keeps repeat phase
      else                    cnt_d = cnt_q + ONE_C;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= REL_C;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;

  assert_release_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_i && !key_i) |=> (cnt_q == REL_C));

  assert_hold_between_polls_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !poll_i |=> $stable(cnt_q));

  assert_cnt_bounded_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q >= REL_C) && (cnt_q <= TOP_C));
endmodule

// File: rtl/key_fire_dec.sv
module key_fire_dec #(
  parameter int unsigned FIRST = 30,
  parameter int unsigned CW    = 7
) (
  input  logic                 poll_i,
  input  logic                 key_i,
  input  logic signed [CW-1:0] cnt_nxt_i,
  output logic                 fire_o
);
  localparam logic signed [CW-1:0] ZERO_C  = '0;
  localparam logic signed [CW-1:0] FIRST_C = CW'(FIRST);

  // counter re-enters FIRST once per repeat interval
  assign fire_o = poll_i && key_i && ((cnt_nxt_i == ZERO_C) || (cnt_nxt_i == FIRST_C));
endmodule

// File: rtl/key_repeat_gen.sv
module key_repeat_gen #(
  parameter int unsigned N_KEYS       = key_rpt_pkg::DEF_KEYS,
  parameter int unsigned FIRST_DELAY  = key_rpt_pkg::DEF_FIRST,
  parameter int unsigned REPEAT_EVERY = key_rpt_pkg::DEF_EVERY
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              poll_i,
  input  logic [N_KEYS-1:0] key_i,
  output logic [N_KEYS-1:0] evt_o
);
  localparam int unsigned CW = key_rpt_pkg::cnt_width(FIRST_DELAY, REPEAT_EVERY);
  localparam logic signed [CW-1:0] REL_C  = '1;
  localparam logic signed [CW-1:0] WAIT_C = CW'(FIRST_DELAY - 1);
  localparam logic signed [CW-1:0] TOP_C  = CW'(FIRST_DELAY + REPEAT_EVERY - 1);

  logic signed [CW-1:0] cnt_w     [N_KEYS];
  logic signed [CW-1:0] cnt_nxt_w [N_KEYS];
  logic [N_KEYS-1:0]    fire_w;
  logic [N_KEYS-1:0]    evt_q;

  for (genvar k = 0; k < N_KEYS; k++) begin : g_key
    key_hold_cnt #(.FIRST(FIRST_DELAY), .EVERY(REPEAT_EVERY), .CW(CW)) i_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .poll_i    (poll_i),
      .key_i     (key_i[k]),
      .cnt_o     (cnt_w[k]),
      .cnt_nxt_o (cnt_nxt_w[k])
    );

    key_fire_dec #(.FIRST(FIRST_DELAY), .CW(CW)) i_dec (
      .poll_i    (poll_i),
      .key_i     (key_i[k]),
      .cnt_nxt_i (cnt_nxt_w[k]),
      .fire_o    (fire_w[k])
    );

    assert_first_press_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (poll_i && key_i[k] && cnt_w[k] == REL_C) |=> evt_q[k]);

    assert_wait_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (poll_i && key_i[k] && !cnt_w[k][CW-1] && cnt_w[k] < WAIT_C) |=> !evt_q[k]);

    assert_repeat_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (poll_i && key_i[k] && cnt_w[k] == TOP_C) |=> evt_q[k]);

    assert_release_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (poll_i && !key_i[k]) |=> !evt_q[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= fire_w;
  end

  assign evt_o = evt_q;

  assert_no_poll_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !poll_i |=> (evt_q == '0));
endmodule

// File: tb/test_key_repeat_gen.sv
`timescale 1ns/1ps
module test_key_repeat_gen;
  localparam int NK = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          poll;
  logic [NK-1:0] key;
  logic [NK-1:0] evt;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit run    = 0;

  int            mdl [NK];
  logic [NK-1:0] exp_evt;

  always #2.5 clk = ~clk;

  key_repeat_gen i_key_repeat_gen (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .poll_i (poll),
    .key_i  (key),
    .evt_o  (evt)
  );

  // reference: unbounded per-key count, fire at 0 or (>=30 and multiple of 6)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NK; k++) mdl[k] = -1;
      exp_evt = '0;
    end else if (poll) begin
      for (int k = 0; k < NK; k++) begin
        if (key[k]) mdl[k] = mdl[k] + 1;
        else        mdl[k] = -1;
        exp_evt[k] = key[k] && (mdl[k] == 0 || (mdl[k] >= 30 && mdl[k] % 6 == 0));
      end
    end else begin
      exp_evt = '0;
    end
  end

  always @(negedge clk) begin
    if (run && rst_n) begin
      checks++;
      if (evt !== exp_evt) begin
        errors++;
        $display("FAIL R7 per-cycle model act=%0h exp=%0h t=%0t", evt, exp_evt, $time);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic poll_step(input logic [NK-1:0] k, output logic [NK-1:0] ev);
    key  = k;
    poll = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ev = evt;
  endtask

  task automatic idle(input logic [NK-1:0] k, input int n);
    for (int i = 0; i < n; i++) begin
      poll = 1'b0;
      key  = k ^ NK'(i & 1);
      @(posedge clk);
      @(negedge clk);
      chk("R6 idle evt", 32'(evt), 32'h0);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog act=hung exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [NK-1:0] ev;
    int n_evt;
    int last_evt;
    rst_n = 1'b0; poll = 1'b0; key = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset evt", 32'(evt), 32'h0);
    rst_n = 1'b1;
    run   = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 32'(evt), 32'h0);

    // 50-poll hold of key 0
    for (int i = 0; i < 50; i++) begin
      if (i == 0) chk("R8 before edge", 32'(evt[0]), 32'h0);
      poll_step(7'h01, ev);
      if (i == 0)       chk("R2 first press", 32'(ev[0]), 32'h1);
      else if (i < 30)  chk("R3 wait quiet", 32'(ev[0]), 32'h0);
      else              chk("R4 repeat", 32'(ev[0]),
                            32'((i == 30 || i == 36 || i == 42 || i == 48) ? 1 : 0));
    end
    poll_step(7'h00, ev);
    chk("R5 release", 32'(ev), 32'h0);
    poll_step(7'h01, ev);
    chk("R5 re-press fires", 32'(ev), 32'h01);
    poll_step(7'h01, ev);
    chk("R5 second poll quiet", 32'(ev), 32'h0);
    poll_step(7'h00, ev);

    // polls gate everything
    poll_step(7'h02, ev);
    chk("R2 key1 press", 32'(ev), 32'h02);
    idle(7'h02, 20);
    poll_step(7'h02, ev);
    chk("R6 count held", 32'(ev), 32'h0);
    idle(7'h00, 5);
    poll_step(7'h02, ev);
    chk("R6 unpolled release ignored", 32'(ev), 32'h0);
    for (int i = 3; i <= 30; i++) begin
      poll_step(7'h02, ev);
      chk("R6 repeat after gaps", 32'(ev[1]), 32'((i == 30) ? 1 : 0));
    end
    poll_step(7'h00, ev);

    // independence
    for (int i = 0; i < 40; i++) begin
      logic [NK-1:0] e;
      poll_step((i >= 10) ? 7'h05 : 7'h01, ev);
      e = '0;
      e[0] = (i == 0 || i == 30 || i == 36);
      e[2] = (i == 10);
      chk("R7 two keys", 32'(ev), 32'(e));
    end
    poll_step(7'h00, ev);

    // long hold: repeats survive counter fold
    n_evt = 0; last_evt = -1;
    for (int i = 0; i < 200; i++) begin
      poll_step(7'h40, ev);
      if (ev[6]) begin n_evt++; last_evt = i; end
    end
    chk("R4 long hold count", 32'(n_evt), 32'd30);
    chk("R4 long hold last", 32'(last_evt), 32'd198);
    poll_step(7'h00, ev);

    // sparse polls
    n_evt = 0;
    for (int i = 0; i < 31; i++) begin
      poll_step(7'h08, ev);
      if (ev[3]) n_evt++;
      if (i == 30) chk("R6 sparse repeat", 32'(ev[3]), 32'h1);
      idle(7'h08, 2);
    end
    chk("R6 sparse count", 32'(n_evt), 32'd2);
    poll_step(7'h00, ev);

    // reset mid-hold
    poll_step(7'h10, ev);
    poll_step(7'h10, ev);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", 32'(evt), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    poll_step(7'h10, ev);
    chk("R1 fire after reset", 32'(ev), 32'h10);
    poll_step(7'h00, ev);

    run  = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule